// File: doc/BRIEF.md
# Monitor Channel Handshake Transmitter

This block sends single bytes to a far-end device over a frame-synchronous monitor channel. Flow control uses two in-frame handshake bits. A host writes one byte while the block is idle. The block then holds that byte in the downstream monitor slot and drives its transmit-valid bit active (low). The slot repeats the byte in every frame until the far end acknowledges it. The acknowledge is the upstream receive bit, which is active low. The transfer pace is set by these bits and not by any clock, so one byte may occupy the channel for any number of frames.

The far end can glitch the acknowledge bit, so the block accepts an acknowledge only when the bit is low at two frame boundaries in a row. After an acknowledge, the block pulses `done` to the host. If 32 frame boundaries pass without an accepted acknowledge, the block abandons the byte and pulses `err`. After either outcome the transmit bit goes high and the slot returns to all ones for one full frame. Only then does `busy` drop and a new byte get accepted. A frame strobe from the surrounding serial framer marks each boundary. The handshake bits are sampled only on that strobe.

Top module: `mon_hs_tx`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `mxBitN` is 1 and `monTxData` is 8'hFF.
- R2: A write (`wrEn`=1) while `busy`=0 is taken on that clock edge. From the next cycle, `busy`=1, `mxBitN`=0 and `monTxData` equals the written byte.
- R3: During a transfer, `monTxData` keeps the written byte and `mxBitN` stays 0 across every frame strobe, until an acknowledge or a timeout is accepted.
- R4: A write while `busy`=1 is ignored, and the byte on `monTxData` does not change.
- R5: An acknowledge is accepted at the second of two consecutive frame strobes that both see `mrBitN`=0. `done` is then 1 for exactly one cycle, in the cycle after that strobe.
- R6: A frame strobe that sees `mrBitN`=1 clears any partial acknowledge. One low frame, then a high frame, then one low frame does not complete a transfer.
- R7: In the cycle that `done` or `err` is 1, `mxBitN` is 1, `monTxData` is 8'hFF and `busy` is still 1. `busy` falls in the cycle after the next frame strobe.
- R8: If no acknowledge has been accepted by the 32nd frame strobe after the write, `err` is 1 for one cycle after that strobe, and `done` stays 0.
- R9: `done` and `err` are never 1 together. An acknowledge completed on the 32nd strobe gives `done` and not `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host byte-write strobe |
| wrData | input | 8 | Host byte to send |
| busy | output | 1 | Transfer or guard frame in progress |
| done | output | 1 | One-cycle pulse: byte acknowledged |
| err | output | 1 | One-cycle pulse: transfer aborted by timeout |
| frameStb | input | 1 | One-cycle frame boundary strobe |
| monTxData | output | 8 | Downstream monitor slot byte |
| mxBitN | output | 1 | Downstream transmit-valid bit, active low |
| mrBitN | input | 1 | Upstream acknowledge bit, active low |

## Verification
A write shows on `busy`, `mxBitN` and `monTxData` one cycle after the edge that takes it. `done`, `err` and the guard-frame outputs change one cycle after the deciding frame strobe. `busy` falls one cycle after the strobe that follows. The bench drives inputs on falling edges. It waits for the rising edge that carries a strobe and reads outputs at the falling edge just after it, so each check falls exactly in the cycle the result is due. A scoreboard queue holds the expected outcome and byte for each write. A monitor pops one entry per `done` or `err` pulse and compares it with the byte last seen on the channel.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } monState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture host byte, clear counters
    logic track;  // a frame boundary during an active send
  } monStrobe_t;

endpackage

// File: rtl/mon_hs_dp.sv
module mon_hs_dp
  import mon_hs_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int ACK_FRAMES     = 2,
  parameter int TIMEOUT_FRAMES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobe_t        strb,
  input  logic              sending,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mrBitN,
  output logic              ackHit,
  output logic              timeoutHit,
  output logic [DATA_W-1:0] monTxData,
  output logic              mxBitN
);

  localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);
  localparam int ACK_W = $clog2(ACK_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_FRAMES - 1);
  localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_FRAMES - 1);
  localparam logic [ACK_W-1:0] ACK_MAX  = ACK_W'(ACK_FRAMES);

  logic [DATA_W-1:0] byteReg;
  logic [ACK_W-1:0]  ackRun;
  logic [CNT_W-1:0]  frameCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteReg  <= '1;
      ackRun   <= '0;
      frameCnt <= '0;
    end else if (strb.load) begin
      byteReg  <= wrData;
      ackRun   <= '0;
      frameCnt <= '0;
    end else if (strb.track) begin
      frameCnt <= frameCnt + 1'b1;
      if (mrBitN)
        ackRun <= '0;
      else if (ackRun != ACK_MAX)
        ackRun <= ackRun + 1'b1;
    end
  end

  assign ackHit     = strb.track && !mrBitN && (ackRun == ACK_LAST);
  assign timeoutHit = strb.track && (frameCnt == CNT_LAST);
  assign monTxData  = sending ? byteReg : '1;
  assign mxBitN     = ~sending;

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sending && $past(sending)) |-> $stable(byteReg));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    sending |-> (frameCnt < CNT_W'(TIMEOUT_FRAMES)));

endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl
  import mon_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       frameStb,
  input  logic       ackHit,
  input  logic       timeoutHit,
  output monStrobe_t strb,
  output logic       sending,
  output logic       busy,
  output logic       done,
  output logic       err
);

  monState_t state, stateNxt;
  logic      doneNxt, errNxt;

  always_comb begin
    stateNxt   = state;
    doneNxt    = 1'b0;
    errNxt     = 1'b0;
    strb.load  = 1'b0;
    strb.track = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (wrEn) begin
          strb.load = 1'b1;
          stateNxt  = ST_SEND;
        end
      end
      ST_SEND: begin
        strb.track = frameStb;
        if (ackHit) begin
          doneNxt  = 1'b1;
          stateNxt = ST_GAP;
        end else if (timeoutHit) begin
          errNxt   = 1'b1;
          stateNxt = ST_GAP;
        end
      end
      ST_GAP: begin
        if (frameStb) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
      err   <= errNxt;
    end
  end

  assign sending = (state == ST_SEND);
  assign busy    = (state != ST_IDLE);

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R7
  guard_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> (!sending && busy));

endmodule

// File: rtl/mon_hs_tx.sv
module mon_hs_tx
  import mon_hs_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int ACK_FRAMES     = 2,
  parameter int TIMEOUT_FRAMES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              frameStb,
  output logic [DATA_W-1:0] monTxData,
  output logic              mxBitN,
  input  logic              mrBitN
);

  monStrobe_t strb;
  logic       sending, ackHit, timeoutHit;

  mon_hs_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .frameStb  (frameStb),
    .ackHit    (ackHit),
    .timeoutHit(timeoutHit),
    .strb      (strb),
    .sending   (sending),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  mon_hs_dp #(
    .DATA_W        (DATA_W),
    .ACK_FRAMES    (ACK_FRAMES),
    .TIMEOUT_FRAMES(TIMEOUT_FRAMES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sending   (sending),
    .wrData    (wrData),
    .mrBitN    (mrBitN),
    .ackHit    (ackHit),
    .timeoutHit(timeoutHit),
    .monTxData (monTxData),
    .mxBitN    (mxBitN)
  );

  // R2
  write_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn) |=> (!mxBitN && monTxData == $past(wrData)));

  // R5
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(frameStb) && !$past(mrBitN)));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(frameStb));

endmodule

// File: tb/test_mon_hs_tx.sv
module test_mon_hs_tx;

  localparam int FRAME_CYC = 16;

  typedef struct {
    bit         isErr;
    logic [7:0] b;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       frameStb = 1'b0;
  logic       mrBitN = 1'b1;
  logic       busy, done, err, mxBitN;
  logic [7:0] monTxData;

  int checks = 0;
  int bad = 0;
  expItem_t expQ[$];
  logic [7:0] lastByte = 8'hFF;

  always #4 clk = ~clk;

  mon_hs_tx i_mon_hs_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .busy(busy), .done(done), .err(err), .frameStb(frameStb),
    .monTxData(monTxData), .mxBitN(mxBitN), .mrBitN(mrBitN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushExp(input bit isErr, input logic [7:0] b);
    expItem_t it;
    it.isErr = isErr;
    it.b = b;
    expQ.push_back(it);
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic passStrobe();
    do @(posedge clk); while (!frameStb);
    @(negedge clk);
  endtask

  // frame strobe generator
  initial begin
    forever begin
      repeat (FRAME_CYC - 1) @(negedge clk);
      frameStb = 1'b1;
      @(negedge clk);
      frameStb = 1'b0;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!mxBitN) lastByte = monTxData;
        if (done || err) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R5/R8 unexpected outcome", {done, err}, 0);
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            check(err == it.isErr && done == !it.isErr, "R9 outcome kind",
                  {done, err}, it.isErr ? 1 : 2);
            check(lastByte == it.b, "R3 byte sent", lastByte, it.b);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    bad++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(mxBitN == 1, "R1 mxBitN", mxBitN, 1);
    check(monTxData == 8'hFF, "R1 monTxData", monTxData, 8'hFF);
    check(done == 0 && err == 0, "R1 done/err", {done, err}, 0);

    // R2 write accepted
    pushExp(1'b0, 8'hA5);
    writeByte(8'hA5);
    check(busy == 1, "R2 busy", busy, 1);
    check(mxBitN == 0, "R2 mxBitN", mxBitN, 0);
    check(monTxData == 8'hA5, "R2 monTxData", monTxData, 8'hA5);

    // R3 repeated across frames without ack
    mrBitN = 1'b1;
    for (int i = 0; i < 3; i++) passStrobe();
    check(monTxData == 8'hA5 && mxBitN == 0, "R3 byte held", monTxData, 8'hA5);

    // R4 write while busy ignored
    writeByte(8'h3C);
    check(monTxData == 8'hA5, "R4 busy write ignored", monTxData, 8'hA5);

    // R6 single low frame then high clears partial ack
    mrBitN = 1'b0;
    passStrobe();
    check(done == 0, "R5 one low frame not enough", done, 0);
    mrBitN = 1'b1;
    passStrobe();
    mrBitN = 1'b0;
    passStrobe();
    check(done == 0 && mxBitN == 0, "R6 partial ack cleared", done, 0);
    passStrobe();
    // R5 done after second consecutive low frame
    check(done == 1, "R5 done pulse", done, 1);
    // R7 guard frame
    check(mxBitN == 1 && monTxData == 8'hFF, "R7 channel idle", monTxData, 8'hFF);
    check(busy == 1, "R7 busy in guard", busy, 1);
    @(negedge clk);
    check(done == 0, "R5 done one cycle", done, 0);
    mrBitN = 1'b1;
    passStrobe();
    check(busy == 0, "R7 busy falls after guard frame", busy, 0);

    // R8 timeout
    pushExp(1'b1, 8'h5A);
    writeByte(8'h5A);
    for (int i = 0; i < 31; i++) passStrobe();
    check(err == 0 && busy == 1 && mxBitN == 0, "R8 no early timeout", err, 0);
    passStrobe();
    check(err == 1 && done == 0, "R8 err on 32nd frame", {done, err}, 1);
    check(mxBitN == 1, "R7 mx high after err", mxBitN, 1);
    passStrobe();
    check(busy == 0, "R7 idle after err guard", busy, 0);

    // R9 ack completing on 32nd strobe wins over timeout
    pushExp(1'b0, 8'hC3);
    writeByte(8'hC3);
    for (int i = 0; i < 30; i++) passStrobe();
    mrBitN = 1'b0;
    passStrobe();
    check(done == 0 && err == 0, "R9 no outcome at 31st", {done, err}, 0);
    passStrobe();
    check(done == 1 && err == 0, "R9 ack wins at 32nd", {done, err}, 2);
    passStrobe();

    // back-to-back quick ack with acknowledge bit left low
    pushExp(1'b0, 8'h00);
    writeByte(8'h00);
    check(monTxData == 8'h00 && mxBitN == 0, "R2 second byte", monTxData, 8'h00);
    passStrobe();
    check(done == 0, "R5 first low frame only", done, 0);
    passStrobe();
    check(done == 1, "R5 quick ack", done, 1);
    mrBitN = 1'b1;
    passStrobe();
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule